// File: doc/BRIEF.md
# Radix-4 Sequential Multiply/Divide Unit

This unit computes the upper 32 bits of a 32 x 32 product and the 32-bit quotient or remainder of a division. It works on an unsigned core that retires two bits per clock. A caller raises `start` for one cycle with an operation code and two operands while the unit is idle. The unit reports `busy` until the answer is ready. It then presents the answer on `result` together with a one-cycle `result_valid` strobe.

Signed operations are handled in three steps. Negative operands are turned into magnitudes first. The unsigned core then runs. The answer is negated at the end when its sign requires it. An unsigned operation always takes 18 cycles. A signed operation spends one extra cycle on the output negation when it is needed. A signed multiply also spends one extra cycle on operand negation. The low-half multiply is not part of this unit; its code is refused.

Latency L is the number of rising edges counted from the edge that samples `start` up to and including the edge after which `result_valid` is high.

Top module: `muldiv_seq`

## Requirements
- R1: Operation codes on `op`: 1 = signed x signed upper half, 2 = signed x unsigned upper half, 3 = unsigned x unsigned upper half, 4 = signed quotient, 5 = unsigned quotient, 6 = signed remainder, 7 = unsigned remainder. A `start` with `op` = 0 is refused: `busy` stays low and no result is produced.
- R2: Codes 3, 5 and 7 have latency 18 for every operand value.
- R3: Codes 4 and 6 have latency 19 when the answer must be negated, and 18 otherwise. For code 4 the answer is negated when the operand signs differ and the divisor is nonzero. For code 6 it is negated when the dividend is negative.
- R4: Codes 1 and 2 have latency 18 when no operand that is treated as signed is negative. The latency is 19 when such operands are negative but the product is not. It is 20 when the product is negative (operand signs differ).
- R5: Multiply codes return bits 63..32 of the exact 64-bit product. Each operand is read as signed or unsigned according to its code.
- R6: The quotient truncates toward zero. A nonzero remainder carries the sign of the dividend.
- R7: A divisor of zero gives a quotient of all ones and a remainder equal to the dividend. This holds for both signed and unsigned codes.
- R8: For a signed divide of 0x80000000 by 0xFFFFFFFF, the quotient is 0x80000000 and the remainder is 0.
- R9: `busy` is high in every cycle after the accepting edge up to the result cycle. `busy` is low while `result_valid` is high. `result_valid` lasts exactly one cycle.
- R10: A `start` raised while `busy` is high is ignored: the running operation keeps its operands, its result and its latency.
- R11: After reset, `busy`, `result_valid` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation (taken only when idle) |
| op | input | 3 | Operation code, see R1 |
| a | input | 32 | Multiplicand or dividend |
| b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| result | output | 32 | Answer, held until the next answer |
| result_valid | output | 1 | One-cycle strobe marking a new answer |

## Verification
The answer is due 18, 19 or 20 rising edges after the edge that samples `start`. The exact count depends on the code and on the operand signs, as R2 to R4 state. The bench computes that count from the operands before it issues the request. It then samples `result_valid` and `busy` at each falling edge after the accepting edge. The edge at which the strobe first appears must equal the predicted count, and `busy` must stay high at every earlier sample. The answer is compared in that same sample against a 64-bit reference product or a reference signed or unsigned division.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam int RADIX_BITS = 2;

  typedef enum logic [2:0] {
    OP_MULLO  = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } md_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_NEGIN,
    ST_ITER,
    ST_FIX,
    ST_FINISH
  } md_state_e;

  function automatic logic op_is_mul(input md_op_e op);
    return ~op[2];
  endfunction

  function automatic logic op_is_rem(input md_op_e op);
    return op[2] & op[1];
  endfunction

  function automatic logic op_sgn_a(input md_op_e op);
    return (op == OP_MULH) || (op == OP_MULHSU) || (op == OP_DIV) || (op == OP_REM);
  endfunction

  function automatic logic op_sgn_b(input md_op_e op);
    return (op == OP_MULH) || (op == OP_DIV) || (op == OP_REM);
  endfunction

endpackage

// File: rtl/md_step.sv
module md_step
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            mul_mode,
  input  logic [XLEN+1:0] hi,
  input  logic [XLEN-1:0] lo,
  input  logic [XLEN-1:0] d,
  output logic [XLEN+1:0] hi_n,
  output logic [XLEN-1:0] lo_n
);

  // radix-4 multiply digit: add lo[1:0] * d, then shift the pair right by two
  logic [XLEN+1:0] mul_sum;
  always_comb begin
    mul_sum = hi;
    if (lo[0]) mul_sum = mul_sum + {2'b00, d};
    if (lo[1]) mul_sum = mul_sum + {1'b0, d, 1'b0};
  end

  // restoring division, one substage per quotient bit
  logic [XLEN-1:0] r_ch [0:RADIX_BITS];
  logic [XLEN-1:0] q_ch [0:RADIX_BITS];
  assign r_ch[0] = hi[XLEN-1:0];
  assign q_ch[0] = lo;

  for (genvar k = 0; k < RADIX_BITS; k++) begin : g_sub
    logic [XLEN:0] trial;
    logic [XLEN:0] diff;
    logic          fits;
    assign trial     = {r_ch[k], q_ch[k][XLEN-1]};
    assign diff      = trial - {1'b0, d};
    assign fits      = ~diff[XLEN];
    assign r_ch[k+1] = fits ? diff[XLEN-1:0] : trial[XLEN-1:0];
    assign q_ch[k+1] = {q_ch[k][XLEN-2:0], fits};
  end

  always_comb begin
    if (mul_mode) begin
      hi_n = {2'b00, mul_sum[XLEN+1:2]};
      lo_n = {mul_sum[1:0], lo[XLEN-1:2]};
    end else begin
      hi_n = {2'b00, r_ch[RADIX_BITS]};
      lo_n = q_ch[RADIX_BITS];
    end
  end

endmodule

// File: rtl/md_ctrl.sv
module md_ctrl
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  md_op_e    op_in,
  input  logic      sa,
  input  logic      sb,
  input  logic      bz,
  output md_state_e st,
  output md_op_e    op_q,
  output logic      sa_q,
  output logic      sb_q,
  output logic      cap,
  output logic      busy
);

  localparam int ITERS = XLEN / RADIX_BITS;
  localparam int CW    = $clog2(ITERS);

  logic [CW-1:0] cnt;
  logic          neg_out_q;
  logic          neg_out_d;

  assign cap  = (st == ST_IDLE) && start && (op_in != OP_MULLO);
  assign busy = (st != ST_IDLE);

  always_comb begin
    if (op_is_mul(op_q))      neg_out_d = sa ^ sb;
    else if (op_is_rem(op_q)) neg_out_d = sa;
    else                      neg_out_d = (sa ^ sb) & ~bz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      op_q      <= OP_MULLO;
      sa_q      <= 1'b0;
      sb_q      <= 1'b0;
      neg_out_q <= 1'b0;
      cnt       <= '0;
    end else begin
      case (st)
        ST_IDLE: if (cap) begin
          op_q <= op_in;
          st   <= ST_SETUP;
        end
        ST_SETUP: begin
          sa_q      <= sa;
          sb_q      <= sb;
          neg_out_q <= neg_out_d;
          cnt       <= '0;
          st        <= (op_is_mul(op_q) && (sa || sb)) ? ST_NEGIN : ST_ITER;
        end
        ST_NEGIN: st <= ST_ITER;
        ST_ITER: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ITERS - 1)) st <= neg_out_q ? ST_FIX : ST_FINISH;
        end
        ST_FIX:    st <= ST_FINISH;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  p_op0_refused_r1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start && op_in == OP_MULLO) |=> (st == ST_IDLE));

  p_iter_span_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ITER && cnt != CW'(ITERS - 1)) |=> (st == ST_ITER));

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(op_q));

endmodule

// File: rtl/md_dpath.sv
module md_dpath
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  md_state_e       st,
  input  md_op_e          op_q,
  input  logic            cap,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sa_q,
  input  logic            sb_q,
  output logic            sa,
  output logic            sb,
  output logic            bz,
  output logic [XLEN-1:0] result,
  output logic            result_valid
);

  logic [XLEN+1:0] hi;
  logic [XLEN-1:0] lo;
  logic [XLEN-1:0] opb;
  logic [XLEN+1:0] hi_n;
  logic [XLEN-1:0] lo_n;
  logic            is_mul;
  logic            is_rem;

  assign is_mul = op_is_mul(op_q);
  assign is_rem = op_is_rem(op_q);
  assign sa     = op_sgn_a(op_q) & lo[XLEN-1];
  assign sb     = op_sgn_b(op_q) & opb[XLEN-1];
  assign bz     = (opb == '0);

  md_step #(.XLEN(XLEN)) u_step (
    .mul_mode (is_mul),
    .hi       (hi),
    .lo       (lo),
    .d        (opb),
    .hi_n     (hi_n),
    .lo_n     (lo_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi           <= '0;
      lo           <= '0;
      opb          <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      case (st)
        ST_IDLE: if (cap) begin
          lo  <= a;
          opb <= b;
          hi  <= '0;
        end
        ST_SETUP: begin
          hi <= '0;
          if (!is_mul) begin
            if (sa) lo  <= -lo;
            if (sb) opb <= -opb;
          end
        end
        ST_NEGIN: begin
          if (sa_q) lo  <= -lo;
          if (sb_q) opb <= -opb;
        end
        ST_ITER: begin
          hi <= hi_n;
          lo <= lo_n;
        end
        ST_FIX: begin
          if (is_mul)      hi[XLEN-1:0] <= ~hi[XLEN-1:0] + {{(XLEN-1){1'b0}}, (lo == '0)};
          else if (is_rem) hi[XLEN-1:0] <= -hi[XLEN-1:0];
          else             lo <= -lo;
        end
        ST_FINISH: begin
          result_valid <= 1'b1;
          result       <= (is_mul || is_rem) ? hi[XLEN-1:0] : lo;
        end
        default: ;
      endcase
    end
  end

  // partial remainder stays below a nonzero divisor throughout the iterations
  p_rem_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ITER && !is_mul && opb != '0) |-> (hi < {2'b00, opb}));

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            busy,
  output logic [XLEN-1:0] result,
  output logic            result_valid
);

  md_state_e st;
  md_op_e    op_q;
  logic      sa, sb, bz, sa_q, sb_q, cap;

  md_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .op_in (md_op_e'(op)),
    .sa    (sa),
    .sb    (sb),
    .bz    (bz),
    .st    (st),
    .op_q  (op_q),
    .sa_q  (sa_q),
    .sb_q  (sb_q),
    .cap   (cap),
    .busy  (busy)
  );

  md_dpath #(.XLEN(XLEN)) u_dpath (
    .clk          (clk),
    .rst          (rst),
    .st           (st),
    .op_q         (op_q),
    .cap          (cap),
    .a            (a),
    .b            (b),
    .sa_q         (sa_q),
    .sb_q         (sb_q),
    .sa           (sa),
    .sb           (sb),
    .bz           (bz),
    .result       (result),
    .result_valid (result_valid)
  );

  p_valid_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !busy);

  p_valid_follows_busy_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(result_valid) |-> $past(busy));

endmodule

// File: tb/muldiv_seq_test.sv
module muldiv_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  op;
  logic [31:0] a, b;
  logic        busy;
  logic [31:0] result;
  logic        result_valid;

  int n_checks = 0;
  int n_err    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_seq #(.XLEN(32)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
    .busy(busy), .result(result), .result_valid(result_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_result(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [63:0] p;
    case (o)
      3'd1: begin p = {{32{x[31]}}, x} * {{32{y[31]}}, y}; return p[63:32]; end
      3'd2: begin p = {{32{x[31]}}, x} * {32'd0, y};       return p[63:32]; end
      3'd3: begin p = {32'd0, x} * {32'd0, y};             return p[63:32]; end
      3'd4: begin
        if (y == 0) return 32'hFFFF_FFFF;
        if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return 32'h8000_0000;
        return 32'($signed(x) / $signed(y));
      end
      3'd5: return (y == 0) ? 32'hFFFF_FFFF : x / y;
      3'd6: begin
        if (y == 0) return x;
        if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return 32'd0;
        return 32'($signed(x) % $signed(y));
      end
      default: return (y == 0) ? x : x % y;
    endcase
  endfunction

  function automatic int ref_latency(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    logic ns_a, ns_b;
    int lat;
    ns_a = x[31] && (o == 1 || o == 2 || o == 4 || o == 6);
    ns_b = y[31] && (o == 1 || o == 4 || o == 6);
    lat = 18;
    if (o < 4) begin
      if (ns_a || ns_b) lat++;
      if (ns_a ^ ns_b)  lat++;
    end else if (o == 4) begin
      if ((ns_a ^ ns_b) && y != 0) lat++;
    end else if (o == 6) begin
      if (ns_a) lat++;
    end
    return lat;
  endfunction

  function automatic string lat_tag(input logic [2:0] o);
    if (o == 3 || o == 5 || o == 7) return "R2";
    if (o == 4 || o == 6) return "R3";
    return "R4";
  endfunction

  function automatic string res_tag(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    if (o < 4) return "R5";
    if (y == 0) return "R7";
    if ((o == 4 || o == 6) && x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return "R8";
    return "R6";
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y, input bit inject);
    int   seen;
    logic busy_ok;
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; op = 3'($urandom); a = $urandom; b = $urandom;
    busy_ok = busy;
    seen = 0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (result_valid) begin seen = i; break; end
      if (!busy) busy_ok = 1'b0;
      if (inject && i == 5) begin start = 1'b1; op = 3'd7; a = ~x; b = 32'd3; end
      if (inject && i == 6) start = 1'b0;
    end
    check(lat_tag(o), 32'(seen), 32'(ref_latency(o, x, y)));
    check("R9", {31'd0, busy_ok & ~busy}, 32'd1);
    check(inject ? "R10" : res_tag(o, x, y), result, ref_result(o, x, y));
    @(negedge clk);
    check("R9", {31'd0, result_valid}, 32'd0);
    if (inject) check("R10", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    rst = 1'b1; start = 1'b0; op = 3'd0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11", {31'd0, busy}, 32'd0);
    check("R11", {31'd0, result_valid}, 32'd0);
    check("R11", result, 32'd0);

    // R1 code 0 refused
    @(negedge clk);
    start = 1'b1; op = 3'd0; a = 32'd7; b = 32'd9;
    @(negedge clk);
    start = 1'b0;
    check("R1", {31'd0, busy}, 32'd0);
    begin
      logic any_valid;
      any_valid = 1'b0;
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (result_valid || busy) any_valid = 1'b1;
      end
      check("R1", {31'd0, any_valid}, 32'd0);
    end

    // directed corners
    run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_op(3'd1, 32'h8000_0000, 32'h8000_0000, 1'b0);
    run_op(3'd1, 32'hFFFF_FFFF, 32'h0000_0002, 1'b0);
    run_op(3'd1, 32'h0000_0005, 32'hFFFF_FFFD, 1'b0);
    run_op(3'd1, 32'h1234_5678, 32'h0000_0100, 1'b0);
    run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_op(3'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_op(3'd1, 32'hFFFF_0000, 32'h0000_0000, 1'b0);
    run_op(3'd4, 32'hFFFF_FFF9, 32'h0000_0002, 1'b0);
    run_op(3'd6, 32'hFFFF_FFF9, 32'h0000_0002, 1'b0);
    run_op(3'd6, 32'h0000_0007, 32'hFFFF_FFFE, 1'b0);
    run_op(3'd4, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b0);
    run_op(3'd4, 32'hFFFF_FFF9, 32'h0000_0000, 1'b0);
    run_op(3'd6, 32'hFFFF_FFF9, 32'h0000_0000, 1'b0);
    run_op(3'd5, 32'h1234_5678, 32'h0000_0000, 1'b0);
    run_op(3'd7, 32'h1234_5678, 32'h0000_0000, 1'b0);
    run_op(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    run_op(3'd6, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    run_op(3'd5, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    run_op(3'd7, 32'h0000_0003, 32'hFFFF_FFFF, 1'b0);
    run_op(3'd4, 32'h0000_0064, 32'h0000_0007, 1'b1);
    run_op(3'd1, 32'hFFFF_FF00, 32'h0000_1000, 1'b1);

    // constrained random
    for (int k = 0; k < 300; k++) begin
      logic [2:0]  ro;
      logic [31:0] ra, rb;
      ro = 3'(1 + ($urandom % 7));
      ra = $urandom;
      rb = $urandom;
      case ($urandom % 6)
        0: rb = rb >> ($urandom % 32);
        1: ra = ra >> ($urandom % 32);
        2: rb = ($urandom % 4 == 0) ? 32'd0 : 32'($signed(-($urandom % 5)));
        default: ;
      endcase
      run_op(ro, ra, rb, (k % 37) == 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule